// File: doc/BRIEF.md
# Execute-Stage Operand Forwarding Unit

This block sits in the execute stage of a five-stage load/store pipeline. It decides, for each of the two ALU source operands, which of three places the value comes from:

- the register-file value latched when the instruction was decoded;
- the ALU result of the instruction one stage ahead, in the memory stage;
- the result of the instruction two stages ahead, in write-back.

It also performs the selection with one three-input multiplexer per operand. The block is purely combinational. Its selects and operands follow the inputs within the same cycle.

A producer only counts when it will write the register file and its destination is not register 0, which always reads as zero. When both later stages target the same register, the memory-stage result wins because it is the newer value. An instruction three stages ahead needs no path, because the register file is written before it is read within one cycle. Stall detection, branch resolution and the pipeline registers belong to other blocks.

Top module: `fwd_unit`

## Requirements
- R1: When the memory-stage instruction writes the register file, its destination is nonzero and it equals an operand's source register, that operand's select is 2'b10 and the operand output equals the memory-stage result.
- R2: When the write-back instruction writes the register file, its destination is nonzero, it equals an operand's source register and R1 does not apply, the select is 2'b01 and the operand equals the write-back result.
- R3: A destination of register 0 never causes forwarding from either stage, even with its write enable set.
- R4: A stage whose register-write enable is low never forwards, even when its destination matches.
- R5: When both stages qualify for the same operand, the memory-stage result is chosen (select 2'b10).
- R6: The two operands are resolved independently: each may take a different source in the same cycle.
- R7: With no qualifying match, the select is 2'b00 and the operand equals the register-file value.
- R8: The select code 2'b11 is never produced.
- R9: The block holds no state: a change on a data input appears on the operand output with no clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rs_idx_i | input | 5 | First source register number of the instruction in execute |
| rt_idx_i | input | 5 | Second source register number of the instruction in execute |
| rs_data_i | input | 32 | Register-file value for the first operand |
| rt_data_i | input | 32 | Register-file value for the second operand |
| mem_dst_i | input | 5 | Destination register of the memory-stage instruction |
| mem_we_i | input | 1 | Memory-stage instruction writes the register file |
| mem_res_i | input | 32 | ALU result held in the memory stage |
| wb_dst_i | input | 5 | Destination register of the write-back instruction |
| wb_we_i | input | 1 | Write-back instruction writes the register file |
| wb_res_i | input | 32 | Value being written back |
| sel_a_o | output | 2 | Source select for the first operand (00 register, 01 write-back, 10 memory stage) |
| sel_b_o | output | 2 | Source select for the second operand, same encoding |
| opnd_a_o | output | 32 | Selected first ALU operand |
| opnd_b_o | output | 32 | Selected second ALU operand |

## Verification
Assertions are checked whenever the inputs change. They cover the following:

- the select never takes the unused code;
- a forwarding select is only raised by an enabled, nonzero, matching producer;
- the memory stage is never passed over when it qualifies;
- each operand output carries the source named by its select.

Some behaviours only the bench scenarios can show:

- the correct operand values along a dependent instruction chain, where one register is produced and then read by the next four instructions;
- independent resolution of the two operands within one cycle;
- a full sweep of register numbers that singles out register 0;
- the absence of state when a data input changes between clock edges.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  localparam int unsigned REG_W  = 5;
  localparam int unsigned DATA_W = 32;

  typedef enum logic [1:0] {
    FWD_REG = 2'b00,
    FWD_WB  = 2'b01,
    FWD_MEM = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/fwd_hit.sv
module fwd_hit #(
  parameter int unsigned REG_W = 5
) (
  input  logic [REG_W-1:0] src_i,
  input  logic [REG_W-1:0] dst_i,
  input  logic             we_i,
  output logic             hit_o
);
  // register 0 is hardwired to zero, never a producer
  logic dst_nz;
  assign dst_nz = |dst_i;
  assign hit_o  = we_i && dst_nz && (dst_i == src_i);
endmodule

// File: rtl/fwd_pick.sv
module fwd_pick
  import fwd_pkg::*;
(
  input  logic     mem_hit_i,
  input  logic     wb_hit_i,
  output fwd_sel_e sel_o
);
  always_comb begin
    if (mem_hit_i)     sel_o = FWD_MEM; // newest value wins
    else if (wb_hit_i) sel_o = FWD_WB;
    else               sel_o = FWD_REG;
  end
endmodule

// File: rtl/fwd_mux3.sv
module fwd_mux3
  import fwd_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  fwd_sel_e          sel_i,
  input  logic [DATA_W-1:0] reg_i,
  input  logic [DATA_W-1:0] wb_i,
  input  logic [DATA_W-1:0] mem_i,
  output logic [DATA_W-1:0] y_o
);
  always_comb begin
    unique case (sel_i)
      FWD_MEM: y_o = mem_i;
      FWD_WB:  y_o = wb_i;
      default: y_o = reg_i;
    endcase
  end
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
  import fwd_pkg::*;
#(
  parameter int unsigned RW = REG_W,
  parameter int unsigned DW = DATA_W
) (
  input  logic [RW-1:0] rs_idx_i,
  input  logic [RW-1:0] rt_idx_i,
  input  logic [DW-1:0] rs_data_i,
  input  logic [DW-1:0] rt_data_i,
  input  logic [RW-1:0] mem_dst_i,
  input  logic          mem_we_i,
  input  logic [DW-1:0] mem_res_i,
  input  logic [RW-1:0] wb_dst_i,
  input  logic          wb_we_i,
  input  logic [DW-1:0] wb_res_i,
  output logic [1:0]    sel_a_o,
  output logic [1:0]    sel_b_o,
  output logic [DW-1:0] opnd_a_o,
  output logic [DW-1:0] opnd_b_o
);
  localparam int unsigned N_OPS = 2;

  logic [RW-1:0] src_idx [N_OPS];
  logic [DW-1:0] src_dat [N_OPS];
  logic [DW-1:0] opnd    [N_OPS];
  fwd_sel_e      sel     [N_OPS];

  assign src_idx[0] = rs_idx_i;
  assign src_idx[1] = rt_idx_i;
  assign src_dat[0] = rs_data_i;
  assign src_dat[1] = rt_data_i;

  for (genvar op = 0; op < N_OPS; op++) begin : g_op
    logic mem_hit, wb_hit;

    fwd_hit #(.REG_W(RW)) u_mem_hit (
      .src_i(src_idx[op]), .dst_i(mem_dst_i), .we_i(mem_we_i), .hit_o(mem_hit)
    );
    fwd_hit #(.REG_W(RW)) u_wb_hit (
      .src_i(src_idx[op]), .dst_i(wb_dst_i), .we_i(wb_we_i), .hit_o(wb_hit)
    );
    fwd_pick u_pick (
      .mem_hit_i(mem_hit), .wb_hit_i(wb_hit), .sel_o(sel[op])
    );
    fwd_mux3 #(.DATA_W(DW)) u_mux (
      .sel_i(sel[op]), .reg_i(src_dat[op]), .wb_i(wb_res_i),
      .mem_i(mem_res_i), .y_o(opnd[op])
    );

    // checks against the port-level view of each operand
    always_comb begin
      a_r8_no_code3: assert (sel[op] != fwd_sel_e'(2'b11));
      if (sel[op] == FWD_MEM)
        a_r1_mem_src_valid: assert (mem_we_i && (mem_dst_i != '0) && (mem_dst_i == src_idx[op]));
      if (sel[op] == FWD_WB)
        a_r2_wb_src_valid: assert (wb_we_i && (wb_dst_i != '0) && (wb_dst_i == src_idx[op]));
      if (mem_we_i && (mem_dst_i != '0) && (mem_dst_i == src_idx[op]))
        a_r5_mem_first: assert (sel[op] == FWD_MEM);
      if (src_idx[op] == '0)
        a_r3_zero_reg: assert (sel[op] == FWD_REG);
      if (sel[op] == FWD_MEM) a_r1_mux_mem: assert (opnd[op] == mem_res_i);
      if (sel[op] == FWD_WB)  a_r2_mux_wb:  assert (opnd[op] == wb_res_i);
      if (sel[op] == FWD_REG) a_r7_mux_reg: assert (opnd[op] == src_dat[op]);
    end
  end

  assign sel_a_o  = sel[0];
  assign sel_b_o  = sel[1];
  assign opnd_a_o = opnd[0];
  assign opnd_b_o = opnd[1];
endmodule

// File: tb/fwd_unit_test.sv
module fwd_unit_test;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk = ~clk;

  logic [4:0]  rs_idx, rt_idx, mem_dst, wb_dst;
  logic        mem_we, wb_we;
  logic [31:0] rs_data, rt_data, mem_res, wb_res;
  logic [1:0]  sel_a, sel_b;
  logic [31:0] opnd_a, opnd_b;

  int total = 0;
  int bad   = 0;

  fwd_unit uut (
    .rs_idx_i(rs_idx), .rt_idx_i(rt_idx), .rs_data_i(rs_data), .rt_data_i(rt_data),
    .mem_dst_i(mem_dst), .mem_we_i(mem_we), .mem_res_i(mem_res),
    .wb_dst_i(wb_dst), .wb_we_i(wb_we), .wb_res_i(wb_res),
    .sel_a_o(sel_a), .sel_b_o(sel_b), .opnd_a_o(opnd_a), .opnd_b_o(opnd_b)
  );

  typedef struct packed {
    logic [4:0] rs; logic [4:0] rt;
    logic [4:0] md; logic       mw;
    logic [4:0] wd; logic       ww;
    logic [1:0] ea; logic [1:0] eb;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t TBL [NV] = '{
    '{5'd2,  5'd5,  5'd2,  1'b1, 5'd0,  1'b0, 2'b10, 2'b00}, // and after sub: R1
    '{5'd6,  5'd2,  5'd12, 1'b1, 5'd2,  1'b1, 2'b00, 2'b01}, // or: R2
    '{5'd2,  5'd2,  5'd13, 1'b1, 5'd12, 1'b1, 2'b00, 2'b00}, // add: R7, sub already written
    '{5'd2,  5'd15, 5'd14, 1'b1, 5'd13, 1'b1, 2'b00, 2'b00}, // sw: R7
    '{5'd7,  5'd7,  5'd7,  1'b1, 5'd7,  1'b1, 2'b10, 2'b10}, // R5 both stages match
    '{5'd0,  5'd0,  5'd0,  1'b1, 5'd0,  1'b1, 2'b00, 2'b00}, // R3 register 0
    '{5'd9,  5'd9,  5'd9,  1'b0, 5'd9,  1'b0, 2'b00, 2'b00}, // R4 enables low
    '{5'd4,  5'd3,  5'd4,  1'b0, 5'd4,  1'b1, 2'b01, 2'b00}, // R4 mem off, wb on
    '{5'd8,  5'd11, 5'd11, 1'b1, 5'd8,  1'b1, 2'b01, 2'b10}, // R6 split sources
    '{5'd31, 5'd31, 5'd31, 1'b1, 5'd0,  1'b1, 2'b10, 2'b10}  // R1 top register
  };

  function automatic logic [31:0] exp_val(input logic [1:0] s, input logic [31:0] r);
    case (s)
      2'b10:   return mem_res;
      2'b01:   return wb_res;
      default: return r;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [1:0] s);
    case (s)
      2'b10:   return "R1";
      2'b01:   return "R2";
      default: return "R7";
    endcase
  endfunction

  task automatic apply(input vec_t v);
    @(posedge clk);
    rs_idx = v.rs; rt_idx = v.rt;
    mem_dst = v.md; mem_we = v.mw;
    wb_dst = v.wd; wb_we = v.ww;
    @(negedge clk);
  endtask

  task automatic chk_ops(input logic [1:0] ea, input logic [1:0] eb);
    chk({tag_of(ea), " sel_a"}, 32'(sel_a), 32'(ea));
    chk({tag_of(eb), " sel_b"}, 32'(sel_b), 32'(eb));
    chk({tag_of(ea), " opnd_a"}, opnd_a, exp_val(ea, rs_data));
    chk({tag_of(eb), " opnd_b"}, opnd_b, exp_val(eb, rt_data));
    chk("R8 code", 32'(sel_a == 2'b11 || sel_b == 2'b11), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rs_idx = '0; rt_idx = '0; mem_dst = '0; wb_dst = '0;
    mem_we = 1'b0; wb_we = 1'b0;
    rs_data = 32'hA0A0_0001; rt_data = 32'hB0B0_0002;
    mem_res = 32'hC1C1_0003; wb_res  = 32'hD2D2_0004;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // quiet state during reset: R7
    chk("R7 reset sel_a", 32'(sel_a), 32'd0);
    chk("R7 reset opnd_b", opnd_b, rt_data);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      apply(TBL[i]);
      chk_ops(TBL[i].ea, TBL[i].eb);
    end

    // R3 sweep: every register forwards from memory stage except 0
    for (int k = 0; k < 32; k++) begin
      vec_t v;
      v = '{5'(k), 5'(k), 5'(k), 1'b1, 5'(k), 1'b1, 2'b00, 2'b00};
      apply(v);
      chk("R3 sweep sel_a", 32'(sel_a), (k == 0) ? 32'd0 : 32'd2);
      chk("R3 sweep opnd_b", opnd_b, (k == 0) ? rt_data : mem_res);
    end

    // R9: data change propagates without a clock edge
    apply('{5'd5, 5'd6, 5'd5, 1'b1, 5'd6, 1'b1, 2'b10, 2'b01});
    chk("R6 sel_b", 32'(sel_b), 32'd1);
    mem_res = 32'h1234_5678;
    wb_res  = 32'h8765_4321;
    #1;
    chk("R9 opnd_a", opnd_a, 32'h1234_5678);
    chk("R9 opnd_b", opnd_b, 32'h8765_4321);
    rs_data = 32'h0F0F_0F0F;
    mem_we = 1'b0;
    #1;
    chk("R4 opnd_a", opnd_a, 32'h0F0F_0F0F);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule